// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a free-running core clock into the timing strobes a serial transmitter or receiver needs. Software-side logic supplies a divisor split into an integer part and a 4-bit sixteenths part. The combined value `integer*16 + fraction` equals sixteen times the counting-clock frequency divided by the wanted baud rate, so one bit lasts `integer + fraction/16` counted clocks on average. Because a bit period can only be a whole number of clocks, a 4-bit accumulator absorbs the fraction once per bit. The period in which the accumulator carries out is made one clock longer than the others.

The block emits a one-cycle bit strobe at the end of every bit period. It also emits an oversample strobe that fires sixteen times per bit, spread evenly, with the last one landing on the bit strobe. A select input chooses what is counted: every core clock, or the rising edges of a slower reference strobe. The reference strobe is first brought into the core domain through a synchronizer chain. A divisor written at any time is only picked up where one bit period ends and the next begins. An integer part of zero parks the generator, which then stays silent.

Top module: `frac_baud_gen`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it is released, neither strobe is asserted.
- R2: With fraction 0 and the core clock selected, bit strobes are exactly `integer` clocks apart, for any integer from 1 up to the largest the width allows.
- R3: With the core clock selected, any 16 consecutive bit periods together last exactly `integer*16 + fraction` clocks.
- R4: Every single bit period lasts either `integer` or `integer + 1` counted clocks, and exactly `fraction` of any 16 consecutive periods are the longer ones.
- R5: A divisor change made in the middle of a bit period does not alter that period; the new value governs the period that starts at the next bit strobe.
- R6: Once a period ends while the integer input is 0, the generator goes idle and both strobes stay low. It starts again on the next counted clock after the integer input becomes nonzero.
- R7: With the select input at 1, the generator counts rising edges of the reference strobe instead of core clocks. If those edges are evenly spaced S clocks apart, then 16 consecutive bit periods last `S*(integer*16 + fraction)` clocks.
- R8: When a bit period is 16 or more counted clocks long, exactly 16 oversample strobes occur in it, and no two of them fall on the same counted clock.
- R9: When a bit period is shorter than 16 counted clocks, the oversample strobe fires on every counted clock of that period.
- R10: Every bit strobe is accompanied in the same cycle by an oversample strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock; all state changes on its rising edge |
| srst_i | input | 1 | Synchronous reset, active high |
| src_sel_i | input | 1 | 0: count every core clock; 1: count rising edges of the reference strobe |
| ref_tick_i | input | 1 | Reference strobe, synchronized inside the block |
| div_int_i | input | INT_W | Integer part of the divisor; 0 parks the generator |
| div_frac_i | input | 4 | Sixteenths part of the divisor |
| bit_tick_o | output | 1 | One-cycle strobe at the end of each bit period |
| os_tick_o | output | 1 | Sixteen-per-bit oversample strobe |

## Verification
The bench builds the generator with an 8-bit integer part and a two-stage reference synchronizer. This width keeps the largest divisor, 255 plus fifteen sixteenths, short enough to sweep in full. It still allows both periods below sixteen clocks, where the oversample strobe runs dense, and periods well above sixteen, where it is spread. The synchronizer depth places a fixed latency between the reference input and the counted edge. Because of that, the bench measures only intervals between strobes, including a run where a reference edge arrives every third clock, and divisor changes at arbitrary points show the boundary rule.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

   // width of the sixteenths part of the divisor
   localparam int FRAC_W  = 4;
   // oversample strobes per bit period
   localparam int OS_RATE = 16;

   typedef enum logic {
      SRC_CORE = 1'b0,
      SRC_REF  = 1'b1
   } src_kind_e;

endpackage

// File: rtl/frac_src_sel.sv
// Produces the count enable: every core clock, or one cycle per rising
// edge of the (optionally synchronized) reference strobe.
module frac_src_sel
   import frac_baud_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic srst_i,
   input  logic src_sel_i,
   input  logic ref_tick_i,
   output logic en_o
);

   logic ref_evt;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES == 1) begin : g_bad_depth
         $error("frac_src_sel: SYNC_STAGES must be 0 or at least 2");
      end

      if (SYNC_STAGES == 0) begin : g_direct
         // reference already lives in the core domain as a one-cycle strobe
         assign ref_evt = ref_tick_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         logic                   prev_q;

         always_ff @(posedge clk_i) begin
            if (srst_i) begin
               sync_q <= '0;
               prev_q <= 1'b0;
            end else begin
               sync_q <= {sync_q[SYNC_STAGES-2:0], ref_tick_i};
               prev_q <= sync_q[SYNC_STAGES-1];
            end
         end

         // rising edge of the synchronized reference
         assign ref_evt = sync_q[SYNC_STAGES-1] & ~prev_q;
      end
   endgenerate

   assign en_o = (src_kind_e'(src_sel_i) == SRC_REF) ? ref_evt : 1'b1;

endmodule

// File: rtl/frac_period_ctl.sv
// Bit-period counter with fractional stretch. The divisor inputs are read
// only when a period starts, so a change never splits a bit.
module frac_period_ctl
   import frac_baud_pkg::*;
#(
   parameter int INT_W = 12
) (
   input  logic              clk_i,
   input  logic              srst_i,
   input  logic              en_i,
   input  logic [INT_W-1:0]  div_int_i,
   input  logic [FRAC_W-1:0] div_frac_i,
   output logic              run_o,
   output logic [INT_W:0]    len_o,
   output logic              end_o
);

   localparam int             LEN_W = INT_W + 1;
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic [LEN_W-1:0]  cnt_q;
   logic [LEN_W-1:0]  len_q;
   logic [FRAC_W-1:0] acc_q;
   logic              run_q;

   logic [FRAC_W:0]   acc_sum;
   logic [LEN_W-1:0]  len_next;
   logic              last_w;
   logic              load_w;
   logic              start_ok;

   always_comb begin
      acc_sum  = {1'b0, acc_q} + {1'b0, div_frac_i};
      // carry out of the sixteenths accumulator lengthens this period
      len_next = {1'b0, div_int_i} + LEN_W'(acc_sum[FRAC_W]);
      last_w   = run_q && ((cnt_q + ONE) == len_q);
      load_w   = en_i && (!run_q || last_w);
      start_ok = (div_int_i != '0);
   end

   always_ff @(posedge clk_i) begin
      if (srst_i) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         len_q <= '0;
         acc_q <= '0;
      end else if (load_w) begin
         cnt_q <= '0;
         if (start_ok) begin
            run_q <= 1'b1;
            len_q <= len_next;
            acc_q <= acc_sum[FRAC_W-1:0];
         end else begin
            run_q <= 1'b0;
            len_q <= '0;
            acc_q <= '0;
         end
      end else if (en_i && run_q) begin
         cnt_q <= cnt_q + ONE;
      end
   end

   assign run_o = run_q;
   assign len_o = len_q;
   assign end_o = en_i && last_w;

endmodule

// File: rtl/frac_os_gen.sv
// Spreads OS_RATE strobes over a period of len_i counted clocks with a
// phase accumulator stepping by OS_RATE and wrapping at len_i.
module frac_os_gen
   import frac_baud_pkg::*;
#(
   parameter int INT_W = 12
) (
   input  logic           clk_i,
   input  logic           srst_i,
   input  logic           en_i,
   input  logic           run_i,
   input  logic [INT_W:0] len_i,
   output logic           os_evt_o
);

   localparam int              LEN_W   = INT_W + 1;
   localparam int              PH_W    = LEN_W + 1;
   localparam logic [PH_W-1:0] OS_STEP = PH_W'(OS_RATE);

   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] ph_sum;
   logic [PH_W-1:0] len_ext;
   logic            dense;
   logic            hit;

   always_comb begin
      ph_sum  = ph_q + OS_STEP;
      len_ext = {1'b0, len_i};
      dense   = (len_i < LEN_W'(OS_RATE));
      hit     = (ph_sum >= len_ext);
   end

   always_ff @(posedge clk_i) begin
      if (srst_i || !run_i) begin
         ph_q <= '0;
      end else if (en_i) begin
         if (dense) begin
            ph_q <= '0;
         end else if (hit) begin
            ph_q <= ph_sum - len_ext;
         end else begin
            ph_q <= ph_sum;
         end
      end
   end

   assign os_evt_o = en_i && run_i && (dense || hit);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
   import frac_baud_pkg::*;
#(
   parameter int INT_W           = 12,
   parameter int REF_SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              srst_i,
   input  logic              src_sel_i,
   input  logic              ref_tick_i,
   input  logic [INT_W-1:0]  div_int_i,
   input  logic [FRAC_W-1:0] div_frac_i,
   output logic              bit_tick_o,
   output logic              os_tick_o
);

   generate
      if (INT_W < 4) begin : g_bad_width
         $error("frac_baud_gen: INT_W must be at least 4");
      end
   endgenerate

   logic           en_w;
   logic           run_w;
   logic           end_w;
   logic           os_w;
   logic [INT_W:0] len_w;
   logic           bit_q;
   logic           os_q;

   frac_src_sel #(
      .SYNC_STAGES (REF_SYNC_STAGES)
   ) u_src (
      .clk_i      (clk_i),
      .srst_i     (srst_i),
      .src_sel_i  (src_sel_i),
      .ref_tick_i (ref_tick_i),
      .en_o       (en_w)
   );

   frac_period_ctl #(
      .INT_W (INT_W)
   ) u_ctl (
      .clk_i      (clk_i),
      .srst_i     (srst_i),
      .en_i       (en_w),
      .div_int_i  (div_int_i),
      .div_frac_i (div_frac_i),
      .run_o      (run_w),
      .len_o      (len_w),
      .end_o      (end_w)
   );

   frac_os_gen #(
      .INT_W (INT_W)
   ) u_os (
      .clk_i    (clk_i),
      .srst_i   (srst_i),
      .en_i     (en_w),
      .run_i    (run_w),
      .len_i    (len_w),
      .os_evt_o (os_w)
   );

   always_ff @(posedge clk_i) begin
      if (srst_i) begin
         bit_q <= 1'b0;
         os_q  <= 1'b0;
      end else begin
         bit_q <= end_w;
         os_q  <= os_w;
      end
   end

   assign bit_tick_o = bit_q;
   assign os_tick_o  = os_q;

endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk (
   input logic clk_i,
   input logic srst_i,
   input logic bit_tick_i,
   input logic os_tick_i,
   input logic run_i
);

   // oversample strobes seen since the last bit strobe
   logic [4:0] os_seen_q;

   always_ff @(posedge clk_i) begin
      if (srst_i || bit_tick_i) begin
         os_seen_q <= '0;
      end else if (os_tick_i && os_seen_q != 5'd31) begin
         os_seen_q <= os_seen_q + 5'd1;
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk_i)
      $past(srst_i) |-> (!bit_tick_i && !os_tick_i));

   assert_idle_silent_R6: assert property (@(posedge clk_i) disable iff (srst_i)
      !run_i |=> (!bit_tick_i && !os_tick_i));

   assert_os_per_bit_R8: assert property (@(posedge clk_i) disable iff (srst_i)
      (os_tick_i && !bit_tick_i) |-> (os_seen_q < 5'd15));

   assert_bit_has_os_R10: assert property (@(posedge clk_i) disable iff (srst_i)
      bit_tick_i |-> os_tick_i);

endmodule

bind frac_baud_gen frac_baud_gen_chk u_chk (
   .clk_i      (clk_i),
   .srst_i     (srst_i),
   .bit_tick_i (bit_tick_o),
   .os_tick_i  (os_tick_o),
   .run_i      (run_w)
);

// File: tb/frac_baud_gen_tb.sv
`timescale 1ns/1ps
module frac_baud_gen_tb;

   localparam int INT_W = 8;
   localparam int SYNC  = 2;
   localparam int N_VEC = 12;
   // stimulus table: counting source, integer part, sixteenths part
   localparam int VEC_SRC  [N_VEC] = '{0, 0, 0, 0, 0,  0,  0,  0, 1,  1, 0,   0};
   localparam int VEC_INT  [N_VEC] = '{1, 5, 7, 3, 2, 16, 20, 17, 4, 18, 1, 255};
   localparam int VEC_FRAC [N_VEC] = '{0, 0, 3, 8, 15, 1, 15,  0, 5,  9, 15, 15};

   logic             clk      = 1'b0;
   logic             srst     = 1'b1;
   logic             src_sel  = 1'b0;
   logic             ref_tick = 1'b0;
   logic [INT_W-1:0] div_int  = '0;
   logic [3:0]       div_frac = '0;
   logic             bit_tick;
   logic             os_tick;

   int total = 0;
   int bad   = 0;
   int ref_ph = 0;

   always #2 clk = ~clk;

   frac_baud_gen #(
      .INT_W           (INT_W),
      .REF_SYNC_STAGES (SYNC)
   ) u_dut (
      .clk_i      (clk),
      .srst_i     (srst),
      .src_sel_i  (src_sel),
      .ref_tick_i (ref_tick),
      .div_int_i  (div_int),
      .div_frac_i (div_frac),
      .bit_tick_o (bit_tick),
      .os_tick_o  (os_tick)
   );

   // reference strobe: high one cycle in every three
   initial begin
      forever begin
         @(negedge clk);
         ref_ph   = (ref_ph == 2) ? 0 : ref_ph + 1;
         ref_tick = (ref_ph == 0);
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // clocks up to and including the next bit strobe, and oversample strobes seen
   task automatic wait_tick(output int clks, output int oss);
      clks = 0;
      oss  = 0;
      do begin
         @(negedge clk);
         clks++;
         if (os_tick) oss++;
      end while (!bit_tick);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      int c;
      int o;
      int acc;
      int quiet;

      // R1: strobes low under reset
      repeat (3) begin
         @(negedge clk);
         check(!bit_tick && !os_tick, "R1", "strobe during reset", bit_tick | os_tick, 0);
      end
      srst = 1'b0;
      @(negedge clk);
      check(!bit_tick && !os_tick, "R1", "strobe after release", bit_tick | os_tick, 0);

      // R6: integer 0 from reset stays silent
      quiet = 0;
      repeat (40) begin
         @(negedge clk);
         if (bit_tick || os_tick) quiet++;
      end
      check(quiet == 0, "R6", "strobes with zero divisor", quiet, 0);

      // table walk
      for (int i = 0; i < N_VEC; i++) begin
         int sp;
         int sum;
         int longc;
         int per;
         int exp_os;
         string req;
         @(negedge clk);
         src_sel  = (VEC_SRC[i] == 1);
         div_int  = INT_W'(VEC_INT[i]);
         div_frac = 4'(VEC_FRAC[i]);
         sp  = (VEC_SRC[i] == 1) ? 3 : 1;
         req = (VEC_SRC[i] == 1) ? "R7" : ((VEC_FRAC[i] == 0) ? "R2" : "R3");
         wait_tick(c, o);   // boundary where the new divisor is picked up
         sum   = 0;
         longc = 0;
         for (int k = 0; k < 16; k++) begin
            wait_tick(c, o);
            sum += c;
            check(os_tick == 1'b1, "R10", "oversample with bit strobe", os_tick, 1);
            check(c == VEC_INT[i] * sp || c == (VEC_INT[i] + 1) * sp, "R4",
                  "single period length", c, VEC_INT[i] * sp);
            per = c / sp;
            if (per > VEC_INT[i]) longc++;
            exp_os = (per >= 16) ? 16 : per;
            check(o == exp_os, (per >= 16) ? "R8" : "R9", "oversample count", o, exp_os);
         end
         check(sum == (VEC_INT[i] * 16 + VEC_FRAC[i]) * sp, req, "16-period total",
               sum, (VEC_INT[i] * 16 + VEC_FRAC[i]) * sp);
         check(longc == VEC_FRAC[i], "R4", "stretched periods", longc, VEC_FRAC[i]);
      end

      // R5: change mid-period
      @(negedge clk);
      src_sel  = 1'b0;
      div_int  = 8'd10;
      div_frac = 4'd0;
      wait_tick(c, o);
      wait_tick(c, o);
      acc = 0;
      repeat (3) begin
         @(negedge clk);
         acc++;
      end
      div_int = 8'd6;
      wait_tick(c, o);
      acc += c;
      check(acc == 10, "R5", "period in progress", acc, 10);
      wait_tick(c, o);
      check(c == 6, "R5", "period after change", c, 6);

      // R6: park while running, then restart
      div_int = 8'd0;
      wait_tick(c, o);
      check(c == 6, "R6", "last period before idle", c, 6);
      quiet = 0;
      repeat (60) begin
         @(negedge clk);
         if (bit_tick || os_tick) quiet++;
      end
      check(quiet == 0, "R6", "strobes while parked", quiet, 0);
      div_int = 8'd4;
      wait_tick(c, o);
      wait_tick(c, o);
      check(c == 4, "R6", "period after restart", c, 4);

      // R1: reset while running
      @(negedge clk);
      srst = 1'b1;
      repeat (2) begin
         @(negedge clk);
         check(!bit_tick && !os_tick, "R1", "strobe during mid-run reset",
               bit_tick | os_tick, 0);
      end
      srst = 1'b0;
      @(negedge clk);
      check(!bit_tick && !os_tick, "R1", "strobe after mid-run release",
            bit_tick | os_tick, 0);

      summary();
   end

endmodule